// File: doc/BRIEF.md
# Programmable Counter/Timer Unit

This block divides a count clock by a 16-bit preset that software loads as two separate byte halves. Once started it runs in one of three modes. In timer mode it reloads at every terminal count and toggles a square-wave output, so the output period is twice the preset in count ticks. This makes it usable as a 16x baud clock source. In counter mode it counts the preset down once and then raises a terminal-count flag. In timeout mode it does the same, but every character-arrival pulse re-arms it. The flag therefore rises only after a quiet gap on the receive line.

The count clock is either the system clock (one tick per cycle) or the rising edges of an external clock input, which is first synchronised. Presets of 0 and 1 are flagged as illegal and a start command is refused while such a value is loaded. The control sequencer has three states. `ST_IDLE` goes to `ST_RUN` on an accepted start. `ST_RUN` has four transitions: it goes back to `ST_IDLE` on stop, it reloads itself on start, it re-arms itself on character arrival in timeout mode, and it goes to `ST_EXPIRED` at terminal count in counter or timeout mode. `ST_EXPIRED` goes to `ST_IDLE` on stop and to `ST_RUN` on start or on a timeout re-arm.

Top module: `ctmr_top`

## Requirements
- R1: The divisor is formed from a low-byte write (`preset_lo_we`) and a high-byte write (`preset_hi_we`) of `wr_data`. After an accepted start, `count_val` equals the full 16-bit divisor in the cycle after the start edge.
- R2: `preset_bad` is high exactly while the loaded divisor is 0 or 1. A start command issued while it is high has no effect, and `busy` stays low.
- R3: In timer mode (`mode_sel`=0), `ctr_out` starts low. It toggles after every n count ticks, where n is the divisor, and the counter reloads each time without stopping. `tc_flag` rises at the first toggle and then stays high.
- R4: In counter mode (`mode_sel`=1, and also `mode_sel`=3), the count reaches terminal count after n ticks. At that point `tc_flag` goes high, `busy` goes low and `count_val` goes to 0, and all three hold until the next command.
- R5: In timeout mode (`mode_sel`=2), a `char_rx` pulse reloads the count with n and clears `tc_flag`. It does this both while counting and after expiry. In the other modes `char_rx` has no effect.
- R6: A stop command (`cmd_stop`, which outranks start) clears `busy`, `tc_flag` and `ctr_out` on the next edge and freezes `count_val`.
- R7: After reset, `busy`, `tc_flag`, `ctr_out` and `count_val` are 0, and the divisor is 0, so `preset_bad` is 1.
- R8: When `clk_src_ext` is 1, the count advances only on rising edges of `ext_clk`, with one tick per edge. Idle system clock cycles do not advance it.
- R9: A start command while running reloads the divisor and restarts the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 8 | Byte written to a divisor half |
| preset_lo_we | input | 1 | Load low byte of divisor |
| preset_hi_we | input | 1 | Load high byte of divisor |
| mode_sel | input | 2 | 0 timer, 1 counter, 2 timeout, 3 counter; captured at start |
| clk_src_ext | input | 1 | 1 selects external count clock |
| ext_clk | input | 1 | External count clock |
| cmd_start | input | 1 | Start/restart pulse |
| cmd_stop | input | 1 | Stop pulse |
| char_rx | input | 1 | Character-arrival pulse |
| ctr_out | output | 1 | Square-wave output |
| tc_flag | output | 1 | Terminal-count flag |
| busy | output | 1 | High while counting |
| preset_bad | output | 1 | Divisor is 0 or 1 |
| count_val | output | 16 | Current count |

## Verification
Two cases are hard to reach from the ports. The first is a timeout re-arm that lands one tick before expiry. The stimulus lets the count reach 1 and then pulses `char_rx` on that very edge, and the bench expects a full fresh window of n ticks. The second is a re-arm after the flag has already risen, which must drop the flag and re-enter the counting state. The external clock path is driven with slow manual edges, and the count is checked between them so that idle system cycles are shown to do nothing.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } ctmr_state_e;

    typedef enum logic [1:0] {
        MD_TIMER   = 2'd0,
        MD_COUNTER = 2'd1,
        MD_TIMEOUT = 2'd2,
        MD_SPARE   = 2'd3
    } ctmr_mode_e;

endpackage

// File: rtl/ctmr_preset.sv
module ctmr_preset #(
    parameter int CNT_W = 16,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              lo_we,
    input  logic              hi_we,
    output logic [CNT_W-1:0]  divisor,
    output logic              divisor_bad
);

    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (lo_we) lo_q <= wr_data;
            if (hi_we) hi_q <= wr_data;
        end
    end

    always_comb begin
        divisor     = {hi_q, lo_q};
        divisor_bad = (divisor < CNT_W'(2));
    end

endmodule

// File: rtl/ctmr_tick.sv
module ctmr_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_ext,
    input  logic ext_clk,
    output logic tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ext_clk;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    always_comb begin
        if (use_ext) tick = sync_q[SYNC_STAGES-1] & ~prev_q;
        else         tick = 1'b1;
    end

endmodule

// File: rtl/ctmr_fsm.sv
module ctmr_fsm
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             char_rx,
    input  logic [1:0]       mode_sel,
    input  logic [CNT_W-1:0] divisor,
    input  logic             divisor_bad,
    output logic             ctr_out,
    output logic             tc_flag,
    output logic             busy,
    output logic [CNT_W-1:0] count_val
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ctmr_state_e      state_q, state_d;
    ctmr_mode_e       mode_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_q;
    logic             out_q;
    logic             tc_q;

    logic ev_stop, ev_start, ev_rearm, ev_term, ev_step;

    always_comb begin
        ev_stop  = cmd_stop;
        ev_start = cmd_start && !cmd_stop && !divisor_bad;
        ev_rearm = char_rx && !ev_stop && !ev_start
                   && (mode_q == MD_TIMEOUT) && (state_q != ST_IDLE);
        ev_term  = (state_q == ST_RUN) && tick && (count_q == ONE)
                   && !ev_stop && !ev_start && !ev_rearm;
        ev_step  = (state_q == ST_RUN) && tick && (count_q > ONE)
                   && !ev_stop && !ev_start && !ev_rearm;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ev_start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (ev_stop)                          state_d = ST_IDLE;
                else if (ev_start || ev_rearm)        state_d = ST_RUN;
                else if (ev_term && mode_q != MD_TIMER) state_d = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (ev_stop)                   state_d = ST_IDLE;
                else if (ev_start || ev_rearm) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
            mode_q   <= MD_TIMER;
            out_q    <= 1'b0;
            tc_q     <= 1'b0;
        end else if (ev_stop) begin
            out_q <= 1'b0;
            tc_q  <= 1'b0;
        end else if (ev_start) begin
            count_q  <= divisor;
            reload_q <= divisor;
            mode_q   <= ctmr_mode_e'(mode_sel);
            out_q    <= 1'b0;
            tc_q     <= 1'b0;
        end else if (ev_rearm) begin
            count_q <= reload_q;
            tc_q    <= 1'b0;
        end else if (ev_term) begin
            tc_q <= 1'b1;
            if (mode_q == MD_TIMER) begin
                count_q <= reload_q;
                out_q   <= ~out_q;
            end else begin
                count_q <= '0;
            end
        end else if (ev_step) begin
            count_q <= count_q - ONE;
        end
    end

    always_comb begin
        ctr_out   = out_q;
        tc_flag   = tc_q;
        busy      = (state_q == ST_RUN);
        count_val = count_q;
    end

endmodule

// File: rtl/ctmr_top.sv
module ctmr_top #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int HALF_W     = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              preset_lo_we,
    input  logic              preset_hi_we,
    input  logic [1:0]        mode_sel,
    input  logic              clk_src_ext,
    input  logic              ext_clk,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              char_rx,
    output logic              ctr_out,
    output logic              tc_flag,
    output logic              busy,
    output logic              preset_bad,
    output logic [CNT_W-1:0]  count_val
);

    logic [CNT_W-1:0] divisor;
    logic             tick;

    ctmr_preset #(.CNT_W(CNT_W)) u_preset (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_data     (wr_data),
        .lo_we       (preset_lo_we),
        .hi_we       (preset_hi_we),
        .divisor     (divisor),
        .divisor_bad (preset_bad)
    );

    ctmr_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_ext (clk_src_ext),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    ctmr_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .char_rx     (char_rx),
        .mode_sel    (mode_sel),
        .divisor     (divisor),
        .divisor_bad (preset_bad),
        .ctr_out     (ctr_out),
        .tc_flag     (tc_flag),
        .busy        (busy),
        .count_val   (count_val)
    );

endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic             cmd_stop,
    input logic             preset_bad,
    input logic             busy,
    input logic             tc_flag,
    input logic             ctr_out,
    input logic [CNT_W-1:0] count_val
);

    AST_BAD_START_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && preset_bad && !busy) |=> !busy); // R2

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (!busy && !tc_flag && !ctr_out)); // R6

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (count_val != '0)); // R4

    AST_TC_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_flag) |-> ($past(count_val) == CNT_W'(1))); // R4

    AST_OUT_ON_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_out != $past(ctr_out)) |-> (tc_flag || $past(cmd_stop) || $past(cmd_start))); // R3

endmodule

bind ctmr_top ctmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_stop   (cmd_stop),
    .preset_bad (preset_bad),
    .busy       (busy),
    .tc_flag    (tc_flag),
    .ctr_out    (ctr_out),
    .count_val  (count_val)
);

// File: tb/ctmr_top_tb.sv
module ctmr_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        preset_lo_we = 1'b0;
    logic        preset_hi_we = 1'b0;
    logic [1:0]  mode_sel = '0;
    logic        clk_src_ext = 1'b0;
    logic        ext_clk = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_stop = 1'b0;
    logic        char_rx = 1'b0;
    logic        ctr_out, tc_flag, busy, preset_bad;
    logic [15:0] count_val;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ctmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
        .preset_lo_we(preset_lo_we), .preset_hi_we(preset_hi_we),
        .mode_sel(mode_sel), .clk_src_ext(clk_src_ext), .ext_clk(ext_clk),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .char_rx(char_rx),
        .ctr_out(ctr_out), .tc_flag(tc_flag), .busy(busy),
        .preset_bad(preset_bad), .count_val(count_val)
    );

    // {mode[36:35], n[34:19], wait[18:3], tc[2], out[1], busy[0]}
    localparam logic [36:0] VEC [10] = '{
        {2'd1, 16'd5,   16'd4,   1'b0, 1'b0, 1'b1},  // R4 before terminal
        {2'd1, 16'd5,   16'd5,   1'b1, 1'b0, 1'b0},  // R4 at terminal
        {2'd0, 16'd3,   16'd2,   1'b0, 1'b0, 1'b1},  // R3 before first toggle
        {2'd0, 16'd3,   16'd3,   1'b1, 1'b1, 1'b1},  // R3 first toggle
        {2'd0, 16'd3,   16'd7,   1'b1, 1'b0, 1'b1},  // R3 second toggle
        {2'd0, 16'd2,   16'd5,   1'b1, 1'b0, 1'b1},  // R3 n=2
        {2'd2, 16'd4,   16'd4,   1'b1, 1'b0, 1'b0},  // R5 expiry untouched
        {2'd3, 16'd300, 16'd299, 1'b0, 1'b0, 1'b1},  // R1 two bytes
        {2'd1, 16'd300, 16'd300, 1'b1, 1'b0, 1'b0},  // R1 R4 long count
        {2'd0, 16'd2,   16'd6,   1'b1, 1'b1, 1'b1}   // R3 third toggle
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] n);
        wr_data = n[7:0]; preset_lo_we = 1'b1;
        cyc(1);
        preset_lo_we = 1'b0; wr_data = n[15:8]; preset_hi_we = 1'b1;
        cyc(1);
        preset_hi_we = 1'b0;
    endtask

    task automatic start_pulse();
        cmd_start = 1'b1; cyc(1); cmd_start = 1'b0;
    endtask

    task automatic stop_pulse();
        cmd_stop = 1'b1; cyc(1); cmd_stop = 1'b0;
    endtask

    task automatic rx_pulse();
        char_rx = 1'b1; cyc(1); char_rx = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R7 reset state
        chk("R7 busy", busy, 0);
        chk("R7 tc", tc_flag, 0);
        chk("R7 out", ctr_out, 0);
        chk("R7 count", count_val, 0);
        chk("R7 preset_bad", preset_bad, 1);
        rst_n = 1'b1;
        cyc(2);

        // table walk
        foreach (VEC[i]) begin
            mode_sel = VEC[i][36:35];
            load(VEC[i][34:19]);
            start_pulse();
            if (i == 7) chk("R1 count after start", count_val, 300);
            cyc(int'(VEC[i][18:3]) - ((i == 7) ? 1 : 0));
            chk($sformatf("vec%0d tc", i),   tc_flag, VEC[i][2]);
            chk($sformatf("vec%0d out", i),  ctr_out, VEC[i][1]);
            chk($sformatf("vec%0d busy", i), busy,    VEC[i][0]);
            stop_pulse();
            cyc(1);
        end

        // R2 illegal presets
        load(16'd1);
        chk("R2 bad at 1", preset_bad, 1);
        mode_sel = 2'd1;
        start_pulse();
        cyc(2);
        chk("R2 start refused", busy, 0);
        load(16'd2);
        chk("R2 ok at 2", preset_bad, 0);

        // R5 re-arm just before expiry, then after expiry
        mode_sel = 2'd2;
        load(16'd4);
        start_pulse();
        cyc(2);                      // count now 2 after 3 edges? start edge + 2 -> 2
        chk("R5 count before rearm", count_val, 2);
        cyc(1);                      // count 1
        rx_pulse();                  // rearm on the would-be terminal edge
        chk("R5 rearm reload", count_val, 4);
        cyc(3);
        chk("R5 still counting", tc_flag, 0);
        cyc(1);
        chk("R5 expired", tc_flag, 1);
        chk("R5 expired busy", busy, 0);
        rx_pulse();
        chk("R5 rearm after expiry tc", tc_flag, 0);
        chk("R5 rearm after expiry busy", busy, 1);
        stop_pulse();

        // R5 char_rx ignored in counter mode
        mode_sel = 2'd1;
        load(16'd5);
        start_pulse();
        cyc(1);
        rx_pulse();
        chk("R5 ignored count", count_val, 3);
        cyc(3);
        chk("R5 ignored tc", tc_flag, 1);
        stop_pulse();

        // R6 stop freezes count and clears outputs
        load(16'd10);
        start_pulse();
        cyc(4);
        stop_pulse();
        cyc(5);
        chk("R6 count frozen", count_val, 6);
        chk("R6 busy", busy, 0);
        chk("R6 tc", tc_flag, 0);
        mode_sel = 2'd0;
        load(16'd2);
        start_pulse();
        cyc(2);
        chk("R6 timer out high", ctr_out, 1);
        stop_pulse();
        chk("R6 out cleared", ctr_out, 0);

        // R9 restart while running
        mode_sel = 2'd1;
        load(16'd5);
        start_pulse();
        cyc(3);
        start_pulse();
        cyc(4);
        chk("R9 restarted tc", tc_flag, 0);
        chk("R9 restarted busy", busy, 1);
        cyc(1);
        chk("R9 terminal", tc_flag, 1);
        stop_pulse();

        // R8 external clock
        clk_src_ext = 1'b1;
        load(16'd2);
        start_pulse();
        cyc(6);
        chk("R8 no ext edge", count_val, 2);
        ext_clk = 1'b1; cyc(6);
        chk("R8 one edge", count_val, 1);
        ext_clk = 1'b0; cyc(6);
        chk("R8 falling ignored", count_val, 1);
        ext_clk = 1'b1; cyc(6);
        chk("R8 second edge tc", tc_flag, 1);
        chk("R8 second edge busy", busy, 0);
        stop_pulse();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule